// File: doc/BRIEF.md
# Special Register Write Unit

This block carries out the "move to special register" operation. Each cycle it may receive a 32-bit instruction word and the value already read from the general register file. When the word has the right fixed fields, the operand is stored in the special register named by the 14-bit address in the low bits of the word.

The block keeps the machine status word and the floating-point status. It also keeps the lower and upper stack limits, the process identifier, zone protection, the translation-table index and the translation-table search register. A 64-entry translation table is held here too. Its lower and upper halves are written through whichever entry the index register currently selects.

When address translation is switched on and the machine runs in user mode, the write is refused and a privilege exception is raised instead. A status write reaches the exported effective status one cycle late. The interrupt-permit output, however, closes at once. In the fast interrupt mode, a status write that enables interrupts also produces a one-cycle acknowledge code.

Top module: `sreg_write_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every special register, every table entry, the effective status, `exc_raise`, `exc_cause` and `irq_ack` become zero.
- R2: A write happens only when `instr_valid` is high and the word has bits[31:26]=6'b100101, bits[25:21]=0 and bits[15:14]=2'b11. Any other word changes no register and raises no exception.
- R3: The special register address is bits[13:0]. Addresses 0x0007, 0x0800, 0x0802, 0x1000, 0x1001, 0x1002 and 0x1005 load `operand` into `fp_status`, `stack_low`, `stack_high`, `proc_id`, `zone_prot`, `tlb_sel` and `tlb_search`. The new value shows after the executing edge.
- R4: Address 0x1003 writes the lower half, and 0x1004 the upper half, of table entry `tlb_sel[5:0]`. The read port `tlb_rd_idx` returns both halves of an entry combinationally.
- R5: A well-formed word with an address outside the map changes no register and raises no exception.
- R6: When `cfg_mmu_en`=1 and status bit 11 (user mode) is 1, a well-formed write changes nothing. Instead `exc_raise` pulses high for the one cycle after the executing edge, and `exc_cause` holds 5'b00111 from then on.
- R7: When `cfg_mmu_en`=0, status bit 11 has no effect: writes proceed and no exception is raised.
- R8: Address 0x0001 writes the status word. `status_q` shows the new value only after the second edge counted from the executing edge.
- R9: When `cfg_fast_irq`=1, a status write with operand bit 1 set makes `irq_ack` 2'b11 for the cycle after the executing edge. Otherwise `irq_ack` is 2'b00. With `cfg_fast_irq`=0 it stays 2'b00.
- R10: `irq_permit` is high only when both the newest status and `status_q` have bit 1 (interrupt enable) set, bit 9 (exception in progress) clear and bit 3 (break in progress) clear. A status write that closes interrupts drops it right after the executing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction word to decode |
| operand | input | 32 | Source general-register value |
| cfg_mmu_en | input | 1 | Address translation in use; enables the privilege check |
| cfg_fast_irq | input | 1 | Fast interrupt mode; enables the acknowledge code |
| tlb_rd_idx | input | 6 | Table entry read index |
| status_q | output | 32 | Effective status word, one cycle behind |
| fp_status | output | 32 | Floating-point status |
| stack_low | output | 32 | Lower stack limit |
| stack_high | output | 32 | Upper stack limit |
| proc_id | output | 32 | Process identifier |
| zone_prot | output | 32 | Zone protection |
| tlb_sel | output | 32 | Table index register |
| tlb_search | output | 32 | Table search register |
| tlb_rd_lo | output | 32 | Lower half of the entry at `tlb_rd_idx` |
| tlb_rd_hi | output | 32 | Upper half of the entry at `tlb_rd_idx` |
| exc_raise | output | 1 | Privilege exception pulse |
| exc_cause | output | 5 | Latched exception cause |
| irq_ack | output | 2 | Interrupt acknowledge code |
| irq_permit | output | 1 | Interrupts may be taken |

## Verification
The assertions assume that configuration inputs change only while no instruction is valid. They also assume that at most one instruction arrives per cycle, each carrying its operand in the same cycle. The bench keeps to this. It drives one instruction at a time on the falling edge, holds it for a single rising edge, and then drops `instr_valid`. It changes `cfg_mmu_en` and `cfg_fast_irq` only in idle cycles. Trap cases enter user mode through a legal status write, so the refused write always follows a recorded status value.

// File: rtl/sreg_pkg.sv
// Package: shared constants, register identifiers and the address map of the
// special register write unit. Assumes a 32-bit data path and 14-bit addresses.
package sreg_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 14;
    localparam int CAUSE_W   = 5;

    // Status word fields that the unit itself decodes
    localparam int ST_IE     = 1;
    localparam int ST_BIP    = 3;
    localparam int ST_EIP    = 9;
    localparam int ST_UM     = 11;

    localparam logic [CAUSE_W-1:0] CAUSE_PRIV = 5'b00111;

    // Fixed instruction fields
    localparam logic [5:0] OPC_MTS  = 6'b100101;
    localparam logic [1:0] SUB_MTS  = 2'b11;

    typedef enum logic [3:0] {
        SR_STATUS = 4'd0,
        SR_FPSTAT = 4'd1,
        SR_STKLO  = 4'd2,
        SR_STKHI  = 4'd3,
        SR_PID    = 4'd4,
        SR_ZONE   = 4'd5,
        SR_TLBSEL = 4'd6,
        SR_TLBLO  = 4'd7,
        SR_TLBHI  = 4'd8,
        SR_SEARCH = 4'd9
    } sreg_id_e;

    localparam int SR_COUNT = 10;

    // Address carried by the instruction for each register identifier
    function automatic logic [ADDR_W-1:0] sreg_addr(input int id);
        case (id)
            0:       sreg_addr = 14'h0001;
            1:       sreg_addr = 14'h0007;
            2:       sreg_addr = 14'h0800;
            3:       sreg_addr = 14'h0802;
            4:       sreg_addr = 14'h1000;
            5:       sreg_addr = 14'h1001;
            6:       sreg_addr = 14'h1002;
            7:       sreg_addr = 14'h1003;
            8:       sreg_addr = 14'h1004;
            default: sreg_addr = 14'h1005;
        endcase
    endfunction

    // True when a status word lets interrupts through
    function automatic logic irq_open(input logic [DATA_W-1:0] st);
        irq_open = st[ST_IE] & ~st[ST_EIP] & ~st[ST_BIP];
    endfunction
endpackage

// File: rtl/sreg_decode.sv
// Module: sreg_decode
// Checks the fixed fields of a move-to-special-register word and produces one
// select line per mapped register. Purely combinational. Assumes the operand
// is supplied separately, so the source register field is not used here.
module sreg_decode
    import sreg_pkg::*;
#(
    parameter int N_REGS = SR_COUNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    output logic              hit,
    output logic [N_REGS-1:0] sel
);
    logic [ADDR_W-1:0] addr;

    // Format check: opcode, zero field and sub-opcode must all match
    always_comb begin
        hit  = instr_valid
             && (instr_word[31:26] == OPC_MTS)
             && (instr_word[25:21] == 5'd0)
             && (instr_word[15:14] == SUB_MTS);
        addr = instr_word[ADDR_W-1:0];
    end

    // One comparator per mapped register
    for (genvar i = 0; i < N_REGS; i++) begin : g_sel
        assign sel[i] = hit && (addr == sreg_addr(i));
    end

    // R3: the address map must never select two registers at once
    a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R2: no select line without a well-formed word
    a_r2_sel_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != '0) |-> hit);
endmodule

// File: rtl/sreg_tlb_store.sv
// Module: sreg_tlb_store
// Translation-table storage: two arrays of words for the lower and upper entry
// halves. It has one write port per half and a shared combinational read port.
// Assumes at most one half is written per cycle.
module sreg_tlb_store #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_lo,
    output logic [WIDTH-1:0] rd_hi
);
    logic [WIDTH-1:0] lo_mem [DEPTH];
    logic [WIDTH-1:0] hi_mem [DEPTH];

    // Clear on reset, otherwise store the addressed half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                lo_mem[e] <= '0;
                hi_mem[e] <= '0;
            end
        end else begin
            if (wr_lo) lo_mem[wr_idx] <= wdata;
            if (wr_hi) hi_mem[wr_idx] <= wdata;
        end
    end

    // Read port for downstream lookup logic
    always_comb begin
        rd_lo = lo_mem[rd_idx];
        rd_hi = hi_mem[rd_idx];
    end

    // R4: the two halves are never written in the same cycle
    a_r4_single_half: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_lo && wr_hi));
endmodule

// File: rtl/sreg_status_ctrl.sv
// Module: sreg_status_ctrl
// Holds the newest status word and its one-cycle-late effective copy. It
// derives the interrupt-permit gate from both copies and produces the
// acknowledge code of the fast interrupt mode.
// Assumes cfg_fast_irq is steady while a write is in flight.
module sreg_status_ctrl
    import sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_status,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cfg_fast_irq,
    output logic [DATA_W-1:0] status_arch,
    output logic [DATA_W-1:0] status_eff,
    output logic              irq_permit,
    output logic [1:0]        irq_ack
);
    // Newest value on the write edge, effective copy one edge later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_arch <= '0;
            status_eff  <= '0;
            irq_ack     <= 2'b00;
        end else begin
            status_eff <= status_arch;
            if (wr_status) status_arch <= wdata;
            irq_ack <= (wr_status && cfg_fast_irq && wdata[ST_IE]) ? 2'b11 : 2'b00;
        end
    end

    // Gate opens only once both copies agree that interrupts are allowed
    always_comb begin
        irq_permit = irq_open(status_arch) && irq_open(status_eff);
    end

    // R10: a write that closes interrupts leaves no open cycle after it
    a_r10_close_at_once: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && !irq_open(wdata)) |=> !irq_permit);

    // R9: the acknowledge code takes only the idle or the fired value
    a_r9_ack_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack == 2'b00) || (irq_ack == 2'b11));

    // R9: a fired code always follows a status write in fast mode
    a_r9_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack == 2'b11) |-> ($past(wr_status) && $past(cfg_fast_irq)));
endmodule

// File: rtl/sreg_write_unit.sv
// Module: sreg_write_unit (top)
// Executes move-to-special-register words: decodes them, checks privilege and
// writes the operand into the addressed register, table half or status word.
// Assumes one instruction per cycle and configuration inputs that change only
// between instructions.
module sreg_write_unit
    import sreg_pkg::*;
#(
    parameter int TLB_DEPTH = 64,
    localparam int TLB_IDX_W = $clog2(TLB_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [31:0]          instr_word,
    input  logic [DATA_W-1:0]    operand,
    input  logic                 cfg_mmu_en,
    input  logic                 cfg_fast_irq,
    input  logic [TLB_IDX_W-1:0] tlb_rd_idx,
    output logic [DATA_W-1:0]    status_q,
    output logic [DATA_W-1:0]    fp_status,
    output logic [DATA_W-1:0]    stack_low,
    output logic [DATA_W-1:0]    stack_high,
    output logic [DATA_W-1:0]    proc_id,
    output logic [DATA_W-1:0]    zone_prot,
    output logic [DATA_W-1:0]    tlb_sel,
    output logic [DATA_W-1:0]    tlb_search,
    output logic [DATA_W-1:0]    tlb_rd_lo,
    output logic [DATA_W-1:0]    tlb_rd_hi,
    output logic                 exc_raise,
    output logic [CAUSE_W-1:0]   exc_cause,
    output logic [1:0]           irq_ack,
    output logic                 irq_permit
);
    logic                    hit;
    logic [SR_COUNT-1:0]     sel;
    logic                    trap;
    logic                    wr_en;
    logic [DATA_W-1:0]       status_arch;
    logic [DATA_W-1:0]       bank_q [SR_COUNT];

    sreg_decode #(.N_REGS(SR_COUNT)) u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .hit         (hit),
        .sel         (sel)
    );

    // Privilege check against the newest status word
    always_comb begin
        trap  = hit && cfg_mmu_en && status_arch[ST_UM];
        wr_en = hit && !trap;
    end

    // Plain register bank; status and table halves are stored elsewhere
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SR_COUNT; i++) bank_q[i] <= '0;
        end else begin
            for (int i = 0; i < SR_COUNT; i++) begin
                if (wr_en && sel[i] && i != int'(SR_STATUS)
                        && i != int'(SR_TLBLO) && i != int'(SR_TLBHI))
                    bank_q[i] <= operand;
            end
        end
    end

    // Exception pulse and held cause code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_raise <= 1'b0;
            exc_cause <= '0;
        end else begin
            exc_raise <= trap;
            if (trap) exc_cause <= CAUSE_PRIV;
        end
    end

    sreg_status_ctrl u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_status    (wr_en && sel[SR_STATUS]),
        .wdata        (operand),
        .cfg_fast_irq (cfg_fast_irq),
        .status_arch  (status_arch),
        .status_eff   (status_q),
        .irq_permit   (irq_permit),
        .irq_ack      (irq_ack)
    );

    sreg_tlb_store #(.DEPTH(TLB_DEPTH), .WIDTH(DATA_W)) u_tlb (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_lo  (wr_en && sel[SR_TLBLO]),
        .wr_hi  (wr_en && sel[SR_TLBHI]),
        .wr_idx (bank_q[SR_TLBSEL][TLB_IDX_W-1:0]),
        .wdata  (operand),
        .rd_idx (tlb_rd_idx),
        .rd_lo  (tlb_rd_lo),
        .rd_hi  (tlb_rd_hi)
    );

    // Present the bank on named ports
    always_comb begin
        fp_status  = bank_q[SR_FPSTAT];
        stack_low  = bank_q[SR_STKLO];
        stack_high = bank_q[SR_STKHI];
        proc_id    = bank_q[SR_PID];
        zone_prot  = bank_q[SR_ZONE];
        tlb_sel    = bank_q[SR_TLBSEL];
        tlb_search = bank_q[SR_SEARCH];
    end

    // R6: a refused write leaves status and table index untouched
    a_r6_trap_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        exc_raise |-> ($stable(status_arch) && $stable(tlb_sel) && $stable(fp_status)));

    // R6: a raised exception carries the privilege cause
    a_r6_cause_code: assert property (@(posedge clk) disable iff (!rst_n)
        exc_raise |-> (exc_cause == CAUSE_PRIV));

    // R7: no exception unless translation was in use
    a_r7_needs_mmu: assert property (@(posedge clk) disable iff (!rst_n)
        exc_raise |-> $past(cfg_mmu_en));

    // R2: an exception only ever follows a valid instruction
    a_r2_exc_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        exc_raise |-> $past(instr_valid));
endmodule

// File: tb/sreg_write_unit_tb.sv
// Directed bench for sreg_write_unit: one task per scenario, each checks itself.
module sreg_write_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [31:0] instr_word;
    logic [31:0] operand;
    logic        cfg_mmu_en;
    logic        cfg_fast_irq;
    logic [5:0]  tlb_rd_idx;
    logic [31:0] status_q, fp_status, stack_low, stack_high, proc_id;
    logic [31:0] zone_prot, tlb_sel, tlb_search, tlb_rd_lo, tlb_rd_hi;
    logic        exc_raise;
    logic [4:0]  exc_cause;
    logic [1:0]  irq_ack;
    logic        irq_permit;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sreg_write_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .operand(operand), .cfg_mmu_en(cfg_mmu_en), .cfg_fast_irq(cfg_fast_irq),
        .tlb_rd_idx(tlb_rd_idx), .status_q(status_q), .fp_status(fp_status),
        .stack_low(stack_low), .stack_high(stack_high), .proc_id(proc_id),
        .zone_prot(zone_prot), .tlb_sel(tlb_sel), .tlb_search(tlb_search),
        .tlb_rd_lo(tlb_rd_lo), .tlb_rd_hi(tlb_rd_hi), .exc_raise(exc_raise),
        .exc_cause(exc_cause), .irq_ack(irq_ack), .irq_permit(irq_permit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_word(input logic [13:0] addr);
        mk_word = {6'b100101, 5'd0, 5'd4, 2'b11, addr};
    endfunction

    // Present one word for one rising edge; returns on the falling edge after it
    task automatic issue(input logic [31:0] word, input logic [31:0] data);
        instr_word  = word;
        operand     = data;
        instr_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
        instr_word  = '0;
    endtask

    task automatic mts(input logic [13:0] addr, input logic [31:0] data);
        issue(mk_word(addr), data);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        mts(14'h0007, 32'hFFFF);
        mts(14'h0001, 32'h2);
        do_reset();
        check("R1 fp_status", fp_status, 0);
        check("R1 status_q", status_q, 0);
        check("R1 tlb_sel", tlb_sel, 0);
        check("R1 exc/ack", {27'd0, exc_raise, exc_cause[1:0], irq_ack}, 0);
        check("R1 permit", {31'd0, irq_permit}, 0);
    endtask

    task automatic t_map();
        mts(14'h0007, 32'h1111_0007);
        mts(14'h0800, 32'h2222_0800);
        mts(14'h0802, 32'h3333_0802);
        mts(14'h1000, 32'h4444_1000);
        mts(14'h1001, 32'h5555_1001);
        mts(14'h1005, 32'h6666_1005);
        check("R3 fp_status", fp_status, 32'h1111_0007);
        check("R3 stack_low", stack_low, 32'h2222_0800);
        check("R3 stack_high", stack_high, 32'h3333_0802);
        check("R3 proc_id", proc_id, 32'h4444_1000);
        check("R3 zone_prot", zone_prot, 32'h5555_1001);
        check("R3 tlb_search", tlb_search, 32'h6666_1005);
        mts(14'h1002, 32'h0000_0045);
        check("R3 tlb_sel", tlb_sel, 32'h45);
    endtask

    task automatic t_tlb();
        mts(14'h1002, 32'd5);
        mts(14'h1003, 32'hA5A5_0005);
        mts(14'h1004, 32'h5A5A_0005);
        mts(14'h1002, 32'd63);
        mts(14'h1004, 32'hBEEF_003F);
        tlb_rd_idx = 6'd5;
        #1;
        check("R4 entry5 lo", tlb_rd_lo, 32'hA5A5_0005);
        check("R4 entry5 hi", tlb_rd_hi, 32'h5A5A_0005);
        tlb_rd_idx = 6'd63;
        #1;
        check("R4 entry63 hi", tlb_rd_hi, 32'hBEEF_003F);
        check("R4 entry63 lo", tlb_rd_lo, 32'h0);
    endtask

    task automatic t_unmapped();
        mts(14'h0002, 32'hDEAD_0001);
        mts(14'h1006, 32'hDEAD_0002);
        check("R5 no exception", {31'd0, exc_raise}, 0);
        check("R5 fp unchanged", fp_status, 32'h1111_0007);
        check("R5 status unchanged", status_q, 0);
    endtask

    task automatic t_bad_format();
        issue({6'b100100, 5'd0, 5'd4, 2'b11, 14'h0007}, 32'hBAD0_0001);
        check("R2 wrong opcode", fp_status, 32'h1111_0007);
        issue({6'b100101, 5'd1, 5'd4, 2'b11, 14'h0007}, 32'hBAD0_0002);
        check("R2 nonzero field", fp_status, 32'h1111_0007);
        issue({6'b100101, 5'd0, 5'd4, 2'b10, 14'h0007}, 32'hBAD0_0003);
        check("R2 wrong subop", fp_status, 32'h1111_0007);
        instr_word = mk_word(14'h0007);
        operand    = 32'hBAD0_0004;
        @(posedge clk);
        @(negedge clk);
        instr_word = '0;
        check("R2 valid low", fp_status, 32'h1111_0007);
    endtask

    task automatic t_status_lag();
        mts(14'h0001, 32'h0000_0010);
        check("R8 lag first edge", status_q, 0);
        @(negedge clk);
        check("R8 visible second edge", status_q, 32'h10);
    endtask

    task automatic t_ack();
        cfg_fast_irq = 1'b0;
        mts(14'h0001, 32'h2);
        check("R9 normal mode no ack", {30'd0, irq_ack}, 0);
        cfg_fast_irq = 1'b1;
        mts(14'h0001, 32'h2);
        check("R9 ack fired", {30'd0, irq_ack}, 32'h3);
        @(negedge clk);
        check("R9 ack returns", {30'd0, irq_ack}, 0);
        mts(14'h0001, 32'h0);
        check("R9 no ack without IE", {30'd0, irq_ack}, 0);
        cfg_fast_irq = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_permit();
        mts(14'h0001, 32'h2);
        check("R10 closed before effective", {31'd0, irq_permit}, 0);
        @(negedge clk);
        check("R10 open", {31'd0, irq_permit}, 1);
        mts(14'h0001, 32'h202);
        check("R10 EIP closes at once", {31'd0, irq_permit}, 0);
        mts(14'h0001, 32'h2);
        @(negedge clk);
        check("R10 reopened", {31'd0, irq_permit}, 1);
        mts(14'h0001, 32'h0);
        check("R10 IE clear closes at once", {31'd0, irq_permit}, 0);
        mts(14'h0001, 32'h2);
        @(negedge clk);
        mts(14'h0001, 32'h0A);
        check("R10 BIP closes at once", {31'd0, irq_permit}, 0);
    endtask

    task automatic t_priv();
        cfg_mmu_en = 1'b1;
        mts(14'h0001, 32'h800);
        check("R6 entering user mode ok", {31'd0, exc_raise}, 0);
        mts(14'h0007, 32'h7777_7777);
        check("R6 trap pulse", {31'd0, exc_raise}, 1);
        check("R6 cause", {27'd0, exc_cause}, 32'h7);
        check("R6 no write", fp_status, 32'h1111_0007);
        @(negedge clk);
        check("R6 pulse ends", {31'd0, exc_raise}, 0);
        check("R6 cause held", {27'd0, exc_cause}, 32'h7);
        mts(14'h0001, 32'h0);
        @(negedge clk);
        check("R6 status kept", status_q, 32'h800);
        cfg_mmu_en = 1'b0;
        mts(14'h0007, 32'h8888_8888);
        check("R7 write without mmu", fp_status, 32'h8888_8888);
        check("R7 no trap", {31'd0, exc_raise}, 0);
        mts(14'h0001, 32'h0);
        @(negedge clk);
        check("R7 status cleared", status_q, 0);
    endtask

    initial begin
        rst_n = 1'b0; instr_valid = 1'b0; instr_word = '0; operand = '0;
        cfg_mmu_en = 1'b0; cfg_fast_irq = 1'b0; tlb_rd_idx = '0;
        @(negedge clk);
        do_reset();
        t_reset();
        t_map();
        t_tlb();
        t_unmapped();
        t_bad_format();
        t_status_lag();
        t_ack();
        t_permit();
        t_priv();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule